// File: doc/BRIEF.md
# Length-Bounded Bulk Prefetch Sequencer

This block turns one bulk prefetch command into a series of cache-line prefetch requests for the memory side. A command gives a starting byte address, a byte length and a kind: read, write, instruction stream or overwrite. The sequencer clamps the length to at most 4096 bytes. It works out which 64-byte lines the clamped span touches and sends one line request per handshake cycle over a valid/ready interface. Because of the clamp, a command can touch no more than two 4 KB pages. The block raises a flag on the one request that first enters a page other than the page of the start address, so that a translation lookup can be started downstream.

An overwrite command expects the lines it covers to be fully rewritten. For this kind, every line that lies wholly inside the span is skipped. Only a partially covered head line and a partially covered tail line are requested. A command with zero length is accepted in one cycle and produces no requests. A new command is taken only while the sequencer is idle. The busy output shows that requests are still pending.

Top module: `bulk_prefetch_seq`

## Requirements
- R1: After reset, req_valid and busy are low and cmd_ready is high.
- R2: cmd_ready equals the inverse of busy. A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. busy rises in the cycle after an accepted command that yields at least one request. busy falls in the cycle after the final request handshake. Commands presented while busy is high are ignored.
- R3: For kinds read (0), write (1) and instruction (2), the block requests every line index from cmd_addr>>6 up to (cmd_addr+L-1)>>6 in ascending order, where L is the clamped length. req_line carries byte address >> 6.
- R4: Any length above 4096 gives the same requests as a length of exactly 4096.
- R5: A length of zero, or an overwrite span with no partially covered line, yields no request, and busy stays low in the cycle after acceptance.
- R6: While req_valid is high and req_ready is low, req_line, req_kind and req_page_cross hold their values.
- R7: req_page_cross is high on the first request of a command whose byte-address bits [31:12] differ from those of cmd_addr, and on no other request of that command.
- R8: For kind overwrite (3), only the first line and the last line are requested, and only when they are partially covered. A line is partially covered when the span does not include all 64 of its bytes. The first line is sent before the last line.
- R9: req_kind repeats the kind of the command that produced the request, encoded as 0 read, 1 write, 2 instruction, 3 overwrite.
- R10: With req_ready held high, requests of a command go out on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Requested byte length |
| cmd_kind | input | 2 | 0 read, 1 write, 2 instruction, 3 overwrite |
| req_valid | output | 1 | Line request present |
| req_ready | input | 1 | Memory side takes the request |
| req_line | output | ADDR_W-6 | Line index (byte address >> 6) |
| req_kind | output | 2 | Kind of the originating command |
| req_page_cross | output | 1 | Request is the first to enter the other page |
| busy | output | 1 | Requests still pending |

## Verification
The bench uses the default parameters: 32-bit addresses, 32-bit lengths, 64-byte lines, 4 KB pages and a 4096-byte clamp. With 32-bit lengths, the bench can apply lengths many times larger than the clamp. With 4 KB pages, a full-length command crosses a page whenever its start address is not aligned to a page. These values make the 65-line worst case, the overwrite head and tail choices and the page flag on a tail-only overwrite all reachable, along with back-pressure at any point in a stream.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  typedef enum logic [1:0] {
    PF_READ      = 2'd0,
    PF_WRITE     = 2'd1,
    PF_INSTR     = 2'd2,
    PF_OVERWRITE = 2'd3
  } pf_kind_e;

endpackage

// File: rtl/bpf_len_clamp.sv
// Bounds the requested byte count with a single compare and select.
module bpf_len_clamp #(
  parameter int LEN_W     = 32,
  parameter int MAX_BYTES = 4096,
  parameter int CL_W      = $clog2(MAX_BYTES) + 1
) (
  input  logic [LEN_W-1:0] len_in,
  output logic [CL_W-1:0]  len_out
);

  localparam logic [LEN_W-1:0] LIMIT_L = LEN_W'(MAX_BYTES);
  localparam logic [CL_W-1:0]  LIMIT_C = CL_W'(MAX_BYTES);

  logic over;

  assign over    = len_in > LIMIT_L;
  assign len_out = over ? LIMIT_C : CL_W'(len_in);

endmodule

// File: rtl/bpf_span_plan.sv
// Works out which lines a command must request and how the walker steps.
module bpf_span_plan #(
  parameter int ADDR_W  = 32,
  parameter int CL_W    = 13,
  parameter int LINE_SH = 6,
  parameter int LN_W    = ADDR_W - LINE_SH
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CL_W-1:0]   clen,
  input  logic              ovw,
  output logic              any,
  output logic [LN_W-1:0]   start_line,
  output logic [LN_W-1:0]   stop_line,
  output logic              jump
);

  logic [ADDR_W-1:0]  end_addr;
  logic [LN_W-1:0]    first_ln;
  logic [LN_W-1:0]    last_ln;
  logic [LINE_SH-1:0] head_off;
  logic [LINE_SH-1:0] tail_off;
  logic               same_ln;
  logic               head_open;
  logic               tail_close;
  logic               head_full;
  logic               tail_full;
  logic               nonzero;

  assign end_addr   = addr + ADDR_W'(clen) - ADDR_W'(1);
  assign first_ln   = addr[ADDR_W-1:LINE_SH];
  assign last_ln    = end_addr[ADDR_W-1:LINE_SH];
  assign head_off   = addr[LINE_SH-1:0];
  assign tail_off   = end_addr[LINE_SH-1:0];
  assign same_ln    = first_ln == last_ln;
  assign head_open  = head_off == '0;
  assign tail_close = &tail_off;
  assign head_full  = head_open && (!same_ln || tail_close);
  assign tail_full  = tail_close && (!same_ln || head_open);
  assign nonzero    = clen != '0;

  always_comb begin
    any        = nonzero;
    start_line = first_ln;
    stop_line  = last_ln;
    jump       = 1'b0;
    if (ovw) begin
      if (same_ln) begin
        any = nonzero && !head_full;
      end else if (!head_full && !tail_full) begin
        jump = 1'b1;
      end else if (!head_full) begin
        stop_line = first_ln;
      end else if (!tail_full) begin
        start_line = last_ln;
      end else begin
        any = 1'b0;
      end
    end
  end

endmodule

// File: rtl/bpf_line_walker.sv
// Holds the active command and emits one registered line request per handshake.
module bpf_line_walker #(
  parameter int LN_W  = 26,
  parameter int PG_SH = 6,
  parameter int PG_W  = LN_W - PG_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LN_W-1:0]  load_start,
  input  logic [LN_W-1:0]  load_stop,
  input  logic             load_jump,
  input  logic [1:0]       load_kind,
  input  logic [PG_W-1:0]  load_page,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [LN_W-1:0]  req_line,
  output logic [1:0]       req_kind,
  output logic             req_page_cross,
  output logic             take
);

  logic [LN_W-1:0] cur_q;
  logic [LN_W-1:0] stop_q;
  logic            jump_q;
  logic [1:0]      kind_q;
  logic [PG_W-1:0] page_q;
  logic            crossed_q;
  logic            cross_q;
  logic            valid_q;

  logic [LN_W-1:0] nxt_line;
  logic            at_end;
  logic            load_cross;
  logic            nxt_cross;

  assign take       = valid_q && req_ready;
  assign at_end     = cur_q == stop_q;
  assign nxt_line   = jump_q ? stop_q : cur_q + LN_W'(1);
  assign load_cross = load_start[LN_W-1:PG_SH] != load_page;
  assign nxt_cross  = !crossed_q && (nxt_line[LN_W-1:PG_SH] != page_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      cur_q     <= '0;
      stop_q    <= '0;
      jump_q    <= 1'b0;
      kind_q    <= '0;
      page_q    <= '0;
      crossed_q <= 1'b0;
      cross_q   <= 1'b0;
    end else if (load) begin
      valid_q   <= 1'b1;
      cur_q     <= load_start;
      stop_q    <= load_stop;
      jump_q    <= load_jump;
      kind_q    <= load_kind;
      page_q    <= load_page;
      cross_q   <= load_cross;
      crossed_q <= load_cross;
    end else if (take) begin
      if (at_end) begin
        valid_q <= 1'b0;
        cross_q <= 1'b0;
      end else begin
        cur_q     <= nxt_line;
        cross_q   <= nxt_cross;
        crossed_q <= crossed_q || nxt_cross;
      end
    end
  end

  assign req_valid      = valid_q;
  assign req_line       = cur_q;
  assign req_kind       = kind_q;
  assign req_page_cross = cross_q;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid_q); // R2

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !req_ready) |=> (valid_q && $stable(cur_q) && $stable(kind_q) && $stable(cross_q))); // R6

  AST_SINGLE_CROSS: assert property (@(posedge clk) disable iff (rst)
    (take && cross_q) |=> !cross_q); // R7

  AST_CROSS_IN_OTHER_PAGE: assert property (@(posedge clk) disable iff (rst)
    cross_q |-> (valid_q && (cur_q[LN_W-1:PG_SH] != page_q))); // R7

endmodule

// File: rtl/bulk_prefetch_seq.sv
module bulk_prefetch_seq #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_BYTES  = 4096
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cmd_valid,
  output logic                               cmd_ready,
  input  logic [ADDR_W-1:0]                  cmd_addr,
  input  logic [LEN_W-1:0]                   cmd_len,
  input  logic [1:0]                         cmd_kind,
  output logic                               req_valid,
  input  logic                               req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] req_line,
  output logic [1:0]                         req_kind,
  output logic                               req_page_cross,
  output logic                               busy
);
  import bpf_pkg::*;

  localparam int LINE_SH   = $clog2(LINE_BYTES);
  localparam int PAGE_SH   = $clog2(PAGE_BYTES);
  localparam int LN_W      = ADDR_W - LINE_SH;
  localparam int PG_SH     = PAGE_SH - LINE_SH;
  localparam int PG_W      = ADDR_W - PAGE_SH;
  localparam int CL_W      = $clog2(MAX_BYTES) + 1;
  localparam int MAX_LINES = MAX_BYTES / LINE_BYTES + 1;
  localparam int CNT_W     = $clog2(MAX_LINES + 1) + 1;

  logic            accept;
  logic            load;
  logic            take;
  logic            w_valid;
  logic [CL_W-1:0] clen;
  logic            plan_any;
  logic [LN_W-1:0] plan_start;
  logic [LN_W-1:0] plan_stop;
  logic            plan_jump;
  pf_kind_e        kind_in;

  assign kind_in = pf_kind_e'(cmd_kind);
  assign accept  = cmd_valid && !w_valid;
  assign load    = accept && plan_any;

  bpf_len_clamp #(
    .LEN_W     (LEN_W),
    .MAX_BYTES (MAX_BYTES),
    .CL_W      (CL_W)
  ) u_clamp (
    .len_in  (cmd_len),
    .len_out (clen)
  );

  bpf_span_plan #(
    .ADDR_W  (ADDR_W),
    .CL_W    (CL_W),
    .LINE_SH (LINE_SH),
    .LN_W    (LN_W)
  ) u_plan (
    .addr       (cmd_addr),
    .clen       (clen),
    .ovw        (kind_in == PF_OVERWRITE),
    .any        (plan_any),
    .start_line (plan_start),
    .stop_line  (plan_stop),
    .jump       (plan_jump)
  );

  bpf_line_walker #(
    .LN_W  (LN_W),
    .PG_SH (PG_SH),
    .PG_W  (PG_W)
  ) u_walk (
    .clk            (clk),
    .rst            (rst),
    .load           (load),
    .load_start     (plan_start),
    .load_stop      (plan_stop),
    .load_jump      (plan_jump),
    .load_kind      (cmd_kind),
    .load_page      (cmd_addr[ADDR_W-1:PAGE_SH]),
    .req_ready      (req_ready),
    .req_valid      (w_valid),
    .req_line       (req_line),
    .req_kind       (req_kind),
    .req_page_cross (req_page_cross),
    .take           (take)
  );

  assign req_valid = w_valid;
  assign busy      = w_valid;
  assign cmd_ready = !w_valid;

  // Per-command count of completed handshakes, used by the checks below.
  logic [CNT_W-1:0] sent_q;
  always_ff @(posedge clk) begin
    if (rst)          sent_q <= '0;
    else if (accept)  sent_q <= '0;
    else if (take)    sent_q <= sent_q + CNT_W'(1);
  end

  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (rst)
    w_valid |-> (sent_q < CNT_W'(MAX_LINES))); // R4

  AST_OVERWRITE_TWO: assert property (@(posedge clk) disable iff (rst)
    (w_valid && req_kind == PF_OVERWRITE) |-> (sent_q <= CNT_W'(1))); // R8

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_len == '0) |=> !busy); // R5

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid)); // R2

endmodule

// File: tb/bulk_prefetch_seq_tb.sv
module bulk_prefetch_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [31:0] cmd_len;
  logic [1:0]  cmd_kind;
  logic        req_valid;
  logic        req_ready;
  logic [25:0] req_line;
  logic [1:0]  req_kind;
  logic        req_page_cross;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  bulk_prefetch_seq u_dut (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_addr       (cmd_addr),
    .cmd_len        (cmd_len),
    .cmd_kind       (cmd_kind),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_line       (req_line),
    .req_kind       (req_kind),
    .req_page_cross (req_page_cross),
    .busy           (busy)
  );

  int vectors = 0;
  int fails   = 0;

  longint unsigned exp_line[$];
  int              exp_cross[$];
  int              exp_kind[$];
  string           cur_tag = "R3";
  bit              stalled = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: list of expected requests for one command.
  task automatic build(input logic [31:0] a, input logic [31:0] l, input logic [1:0] k);
    longint unsigned clen, first, last, e, pg;
    bit hfull, tfull, crossed;
    longint unsigned lst[$];
    clen = (l > 32'd4096) ? 4096 : longint'(l);
    if (clen == 0) return;
    e     = longint'(a) + clen - 1;
    first = longint'(a) >> 6;
    last  = e >> 6;
    if (k != 2'd3) begin
      for (longint unsigned x = first; x <= last; x++) lst.push_back(x);
    end else begin
      hfull = (a % 64 == 0) && (last != first || e % 64 == 63);
      tfull = (e % 64 == 63) && (last != first || a % 64 == 0);
      if (!hfull) lst.push_back(first);
      if (last != first && !tfull) lst.push_back(last);
    end
    pg = longint'(a) >> 12;
    crossed = 1'b0;
    foreach (lst[i]) begin
      bit c;
      c = !crossed && ((lst[i] >> 6) != pg);
      if (c) crossed = 1'b1;
      exp_line.push_back(lst[i]);
      exp_cross.push_back(int'(c));
      exp_kind.push_back(int'(k));
    end
  endtask

  // Called just after a falling edge: drive, compare, update model, advance one cycle.
  task automatic cycle(input bit cv, input logic [31:0] a, input logic [31:0] l,
                       input logic [1:0] k, input bit rdy);
    bit pend;
    cmd_valid = cv; cmd_addr = a; cmd_len = l; cmd_kind = k; req_ready = rdy;
    #1;
    pend = exp_line.size() != 0;
    check(cmd_ready == !pend, "R2 cmd_ready", cmd_ready, !pend);
    check(busy == pend, (cur_tag == "R5") ? "R5 busy" : "R2 busy", busy, pend);
    check(req_valid == pend, (cur_tag == "R5") ? "R5 req_valid" : "R10 req_valid", req_valid, pend);
    if (pend && req_valid) begin
      check(longint'(req_line) == exp_line[0], stalled ? "R6 line" : cur_tag, req_line, exp_line[0]);
      check(int'(req_kind) == exp_kind[0], "R9 kind", req_kind, exp_kind[0]);
      check(int'(req_page_cross) == exp_cross[0], "R7 page_cross", req_page_cross, exp_cross[0]);
    end
    stalled = pend && !rdy;
    if (pend && rdy) begin
      void'(exp_line.pop_front());
      void'(exp_cross.pop_front());
      void'(exp_kind.pop_front());
    end else if (!pend && cv) begin
      build(a, l, k);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [31:0] a, input logic [31:0] l, input logic [1:0] k,
                         input bit rand_ready, input string tag);
    cur_tag = tag;
    cycle(1'b1, a, l, k, 1'b1);
    while (exp_line.size() != 0) begin
      // A different command held on the input while busy must be ignored (R2).
      cycle(1'b1, ~a, 32'd640, ~k, rand_ready ? bit'($urandom % 2) : 1'b1);
    end
    cycle(1'b0, 32'd0, 32'd0, 2'd0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_kind = '0; req_ready = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);

    run_cmd(32'h0000_1000, 32'd256,    2'd0, 1'b0, "R3");   // aligned read, 4 lines
    run_cmd(32'h0000_1030, 32'd100,    2'd1, 1'b1, "R3");   // unaligned write
    run_cmd(32'h0000_2000, 32'd1,      2'd2, 1'b0, "R3");   // one byte, instruction
    run_cmd(32'h0000_2000, 32'd0,      2'd0, 1'b0, "R5");   // zero length
    run_cmd(32'h0001_0008, 32'd100000, 2'd0, 1'b0, "R4");   // clamp, 65 lines, crosses page
    run_cmd(32'h0001_0008, 32'd4096,   2'd1, 1'b1, "R4");   // exactly at the bound
    run_cmd(32'h0000_2F80, 32'd512,    2'd0, 1'b1, "R7");   // page crossing mid stream
    run_cmd(32'h0000_4000, 32'd128,    2'd3, 1'b0, "R5");   // overwrite fully covered
    run_cmd(32'h0000_4010, 32'd200,    2'd3, 1'b1, "R8");   // overwrite head and tail
    run_cmd(32'h0000_4010, 32'd112,    2'd3, 1'b0, "R8");   // overwrite head only
    run_cmd(32'h0000_5000, 32'd100,    2'd3, 1'b0, "R8");   // overwrite tail only
    run_cmd(32'h0000_6004, 32'd8,      2'd3, 1'b0, "R8");   // overwrite inside one line
    run_cmd(32'h0000_7FC0, 32'd100,    2'd3, 1'b0, "R8");   // tail-only in next page (R7)
    run_cmd(32'h0000_9010, 32'd9000,   2'd3, 1'b1, "R8");   // overwrite with clamp

    for (int n = 0; n < 150; n++) begin
      logic [31:0] a, l;
      logic [1:0]  k;
      a = $urandom & 32'h0FFF_FFFF;
      case ($urandom % 4)
        0: l = $urandom % 200;
        1: l = $urandom % 5000;
        2: l = $urandom;
        default: l = $urandom % 130;
      endcase
      k = 2'($urandom % 4);
      run_cmd(a, l, k, bit'(n % 2), (k == 2'd3) ? "R8" : ((l > 4096) ? "R4" : "R3"));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule